// File: doc/BRIEF.md
# Interleaved I/Q DDR Sample Port

This block sits between a radio transceiver's 12-bit parallel sample ports and the chip's sample buffering. The transceiver sends a receive stream in which I and Q words alternate on the two edges of a DDR clock that runs at the sample rate. An I word is taken on each rising edge and a Q word on the following falling edge. A frame line says which half a word belongs to. Complete pairs are packed as `{Q, I}` into 24-bit words and written into a receive FIFO, at most one per clock period. The frame line realigns the pairing by itself: a pair is only formed when it shows the I half on the rise and the Q half on the fall.

On the transmit side, 24-bit `{Q, I}` samples are written into a transmit FIFO. While the block is enabled it pops one sample per clock period and drives I during the clock-high phase and Q during the clock-low phase. A frame output is high during the I half. If the FIFO runs dry, zeros are sent and a sticky underflow flag is raised. A receive FIFO that overflows drops the new sample and raises a sticky overflow flag. A test mode replaces received data with a 12-bit ramp so that rate and integrity can be checked downstream. One enable gates both directions.

Top module: `iq_ddr_port`

## Requirements
- R1: After reset, rx_empty_o is 1, rx_ovf_o and tx_udf_o are 0, and tx_ddr_data_o and tx_ddr_frame_o are 0.
- R2: With en_i high and ramp mode off, a word sampled on a rising edge with frame high, followed by a word sampled on the next falling edge with frame low, is written to the receive FIFO as {Q in bits 23:12, I in bits 11:0} on the next rising edge.
- R3: A rising-edge word with frame low, or a falling-edge word with frame high, forms no sample. Pairing resumes with the next correctly framed rise/fall pair.
- R4: A sample offered while the receive FIFO is full is dropped, the stored samples are kept, and rx_ovf_o goes to 1 and stays there until reset.
- R5: While en_i is high and the transmit FIFO is not empty, each rising edge pops one sample. For the following clock period, tx_ddr_data_o carries I (bits 11:0) with tx_ddr_frame_o high during the clock-high phase, and Q (bits 23:12) with tx_ddr_frame_o low during the clock-low phase.
- R6: A rising edge with en_i high and the transmit FIFO empty drives zeros for both I and Q in that period and sets tx_udf_o, which stays 1 until reset.
- R7: While en_i is low, no sample enters the receive FIFO, the transmit FIFO is not popped, tx_ddr_data_o and tx_ddr_frame_o are 0, and tx_udf_o is not set.
- R8: With en_i and ramp_en_i both high, every rising edge offers the receive FIFO a sample whose I and Q fields both equal a 12-bit counter. The counter is 0 after reset and increments on every such edge.
- R9: The receive FIFO is show-ahead: rx_sample_o shows the oldest sample while rx_empty_o is 0, and rx_pop_i on a rising edge advances to the next sample in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DDR sample clock, one period per I/Q pair |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables both directions |
| ramp_en_i | input | 1 | Replaces receive data with a counter ramp |
| rx_ddr_data_i | input | 12 | Receive word, I on rise and Q on fall |
| rx_ddr_frame_i | input | 1 | Receive frame, high during the I half |
| rx_pop_i | input | 1 | Pops the receive FIFO head |
| rx_sample_o | output | 24 | Receive FIFO head, {Q, I} |
| rx_empty_o | output | 1 | Receive FIFO empty |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| tx_push_i | input | 1 | Writes tx_sample_i into the transmit FIFO |
| tx_sample_i | input | 24 | Transmit sample, {Q, I} |
| tx_full_o | output | 1 | Transmit FIFO full, pushes are discarded |
| tx_ddr_data_o | output | 12 | Transmit word, I in high phase and Q in low phase |
| tx_ddr_frame_o | output | 1 | Transmit frame, high during the I half |
| tx_udf_o | output | 1 | Sticky transmit underflow |

## Verification
A receive pair whose I is taken on rising edge k and whose Q is taken on the falling edge after it appears at rx_sample_o just after rising edge k+1. The bench therefore inspects the FIFO head only at falling edges after that edge, and pops on the rising edge that follows. A transmit sample popped on rising edge k is checked half a nanosecond after edge k for I and frame high, and half a nanosecond after the next falling edge for Q and frame low. Both sticky flags change on the rising edge that causes them, so they are read after that edge has passed. Inputs always change half a nanosecond after a clock edge, so no check depends on the order in which processes run at an edge.

// File: rtl/iq_ddr_pkg.sv
`timescale 1ns/1ps
package iq_ddr_pkg;
  localparam int unsigned IqW = 12;
  typedef logic [IqW-1:0] iq_word_t;
  typedef struct packed {
    iq_word_t q;
    iq_word_t i;
  } iq_pair_t;
endpackage

// File: rtl/iq_fifo.sv
`timescale 1ns/1ps
// Show-ahead single-clock FIFO; DEPTH must be a power of two, at least 2.
module iq_fifo #(
  parameter int unsigned W     = 24,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wr_q, rd_q;
  logic         do_push, do_pop;

  assign empty_o = (wr_q == rd_q);
  assign full_o  = (wr_q == {~rd_q[AW], rd_q[AW-1:0]});
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q[AW-1:0]] <= data_i;
  end
endmodule

// File: rtl/iq_rx_deint.sv
`timescale 1ns/1ps
module iq_rx_deint import iq_ddr_pkg::*; (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     ramp_i,
  input  iq_word_t ddr_data_i,
  input  logic     ddr_frame_i,
  output logic     push_o,
  output iq_pair_t pair_o
);
  iq_word_t rise_q, fall_q, ramp_q;
  logic     rise_frm_q, fall_frm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q     <= '0;
      rise_frm_q <= 1'b0;
    end else begin
      rise_q     <= ddr_data_i;
      rise_frm_q <= ddr_frame_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_q     <= '0;
      fall_frm_q <= 1'b0;
    end else begin
      fall_q     <= ddr_data_i;
      fall_frm_q <= ddr_frame_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ramp_q <= '0;
    else if (en_i && ramp_i)  ramp_q <= ramp_q + iq_word_t'(1);
  end

  // A pair is valid only with I framed on the rise and Q unframed on the fall.
  assign push_o = en_i & (ramp_i | (rise_frm_q & ~fall_frm_q));

  always_comb begin
    if (ramp_i) begin
      pair_o.q = ramp_q;
      pair_o.i = ramp_q;
    end else begin
      pair_o.q = fall_q;
      pair_o.i = rise_q;
    end
  end
endmodule

// File: rtl/iq_tx_inter.sv
`timescale 1ns/1ps
module iq_tx_inter import iq_ddr_pkg::*; (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     empty_i,
  input  iq_pair_t head_i,
  output logic     pop_o,
  output logic     udf_o,
  output iq_word_t ddr_data_o,
  output logic     ddr_frame_o
);
  iq_pair_t cur_q;
  logic     act_q;

  assign pop_o = en_i & ~empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      act_q <= 1'b0;
      udf_o <= 1'b0;
    end else begin
      cur_q <= pop_o ? head_i : '0;
      act_q <= en_i;
      udf_o <= udf_o | (en_i & empty_i);
    end
  end

  // DDR output: clock level selects the half being driven.
  assign ddr_data_o  = clk_i ? cur_q.i : cur_q.q;
  assign ddr_frame_o = clk_i & act_q;
endmodule

// File: rtl/iq_ddr_port.sv
`timescale 1ns/1ps
module iq_ddr_port import iq_ddr_pkg::*; #(
  parameter int unsigned RX_DEPTH = 8,
  parameter int unsigned TX_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ramp_en_i,
  input  logic [IqW-1:0]    rx_ddr_data_i,
  input  logic              rx_ddr_frame_i,
  input  logic              rx_pop_i,
  output logic [2*IqW-1:0]  rx_sample_o,
  output logic              rx_empty_o,
  output logic              rx_ovf_o,
  input  logic              tx_push_i,
  input  logic [2*IqW-1:0]  tx_sample_i,
  output logic              tx_full_o,
  output logic [IqW-1:0]    tx_ddr_data_o,
  output logic              tx_ddr_frame_o,
  output logic              tx_udf_o
);
  localparam int unsigned PairW = 2 * IqW;

  logic     rx_push, rx_full, tx_pop, tx_empty;
  iq_pair_t rx_pair, tx_head;

  iq_rx_deint u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .ramp_i      (ramp_en_i),
    .ddr_data_i  (rx_ddr_data_i),
    .ddr_frame_i (rx_ddr_frame_i),
    .push_o      (rx_push),
    .pair_o      (rx_pair)
  );

  iq_fifo #(.W(PairW), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .data_i  (rx_pair),
    .pop_i   (rx_pop_i),
    .data_o  (rx_sample_o),
    .empty_o (rx_empty_o),
    .full_o  (rx_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_ovf_o <= 1'b0;
    else         rx_ovf_o <= rx_ovf_o | (rx_push & rx_full);
  end

  iq_fifo #(.W(PairW), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_push_i),
    .data_i  (tx_sample_i),
    .pop_i   (tx_pop),
    .data_o  (tx_head),
    .empty_o (tx_empty),
    .full_o  (tx_full_o)
  );

  iq_tx_inter u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .empty_i     (tx_empty),
    .head_i      (tx_head),
    .pop_o       (tx_pop),
    .udf_o       (tx_udf_o),
    .ddr_data_o  (tx_ddr_data_o),
    .ddr_frame_o (tx_ddr_frame_o)
  );
endmodule

// File: rtl/iq_ddr_port_chk.sv
`timescale 1ns/1ps
module iq_ddr_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic rx_empty_o,
  input logic rx_ovf_o,
  input logic rx_full,
  input logic tx_udf_o,
  input logic tx_empty
);
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovf_o |=> rx_ovf_o); // R4
  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ovf_o) |-> $past(rx_full)); // R4
  AST_UDF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_udf_o |=> tx_udf_o); // R6
  AST_UDF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_udf_o) |-> ($past(en_i) && $past(tx_empty))); // R6
  AST_DIS_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && rx_empty_o) |=> rx_empty_o); // R7
  AST_RX_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_full && rx_empty_o)); // R9
endmodule

bind iq_ddr_port iq_ddr_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .rx_empty_o (rx_empty_o),
  .rx_ovf_o   (rx_ovf_o),
  .rx_full    (rx_full),
  .tx_udf_o   (tx_udf_o),
  .tx_empty   (tx_empty)
);

// File: tb/iq_ddr_port_bench.sv
`timescale 1ns/1ps
module iq_ddr_port_bench;
  localparam int RXD = 8;
  localparam int TXD = 8;

  logic        clk = 1'b0;
  logic        rst_n, en, ramp, rx_frame, rx_pop, tx_push;
  logic [11:0] rx_data;
  logic [23:0] rx_sample, tx_sample;
  logic        rx_empty, rx_ovf, tx_full, tx_frame, tx_udf;
  logic [11:0] tx_data;

  always #2 clk = ~clk;

  iq_ddr_port #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) u_iq_ddr_port (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ramp_en_i(ramp),
    .rx_ddr_data_i(rx_data), .rx_ddr_frame_i(rx_frame), .rx_pop_i(rx_pop),
    .rx_sample_o(rx_sample), .rx_empty_o(rx_empty), .rx_ovf_o(rx_ovf),
    .tx_push_i(tx_push), .tx_sample_i(tx_sample), .tx_full_o(tx_full),
    .tx_ddr_data_o(tx_data), .tx_ddr_frame_o(tx_frame), .tx_udf_o(tx_udf)
  );

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_rx[$];
  logic [23:0] exp_tx[$];

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; ramp = 1'b0; rx_frame = 1'b0; rx_pop = 1'b0;
    tx_push = 1'b0; rx_data = '0; tx_sample = '0;
    exp_rx.delete(); exp_tx.delete();
    repeat (2) @(posedge clk);
    @(negedge clk); #0.5 rst_n = 1'b1;
  endtask

  // Driver: one DDR period on the receive port; records the expected sample.
  task automatic send_pair(input logic [11:0] i, input logic [11:0] q,
                           input logic f_rise, input logic f_fall, input bit valid);
    @(negedge clk); #0.5 rx_data = i; rx_frame = f_rise;
    @(posedge clk); #0.5 rx_data = q; rx_frame = f_fall;
    if (valid && exp_rx.size() < RXD) exp_rx.push_back({q, i});
  endtask

  // Monitor: pops the receive FIFO and compares against the scoreboard.
  task automatic drain_rx(input string req);
    logic [23:0] e;
    @(posedge clk);
    forever begin
      @(negedge clk); #0.5;
      if (rx_empty) break;
      e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 24'hxxxxxx;
      chk(req, rx_sample, e);
      rx_pop = 1'b1;
      @(posedge clk); #0.5 rx_pop = 1'b0;
    end
    chk({req, " leftover"}, 24'(exp_rx.size()), 24'd0);
    exp_rx.delete();
  endtask

  task automatic tx_send(input logic [23:0] s);
    @(negedge clk); #0.5 tx_push = 1'b1; tx_sample = s;
    exp_tx.push_back(s);
    @(posedge clk); #0.5 tx_push = 1'b0;
  endtask

  task automatic tx_watch(input int n);
    logic [23:0] e;
    string tag;
    for (int k = 0; k < n; k++) begin
      tag = (exp_tx.size() > 0) ? "R5" : "R6";
      e = (exp_tx.size() > 0) ? exp_tx.pop_front() : 24'h0;
      @(posedge clk); #0.5;
      chk({tag, " I half"}, 24'(tx_data), 24'(e[11:0]));
      chk({tag, " frame high"}, 24'(tx_frame), 24'd1);
      @(negedge clk); #0.5;
      chk({tag, " Q half"}, 24'(tx_data), 24'(e[23:12]));
      chk({tag, " frame low"}, 24'(tx_frame), 24'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk); #0.5;
    chk("R1 rx_empty", 24'(rx_empty), 24'd1);
    chk("R1 rx_ovf", 24'(rx_ovf), 24'd0);
    chk("R1 tx_udf", 24'(tx_udf), 24'd0);
    chk("R1 tx_data", 24'(tx_data), 24'd0);
    @(posedge clk); #0.5;
    chk("R1 tx_frame", 24'(tx_frame), 24'd0);

    // R7: transmit held while disabled; FIFO keeps its contents.
    tx_send(24'hABC123);
    tx_send(24'h000FFF);
    tx_send(24'h5A5A5A);
    @(posedge clk); #0.5;
    chk("R7 tx_data disabled", 24'(tx_data), 24'd0);
    chk("R7 tx_frame disabled", 24'(tx_frame), 24'd0);
    chk("R7 tx_udf disabled", 24'(tx_udf), 24'd0);

    // R5 then R6: three popped samples, then an empty period.
    @(negedge clk); #0.5 en = 1'b1;
    tx_watch(4);
    chk("R6 tx_udf sticky", 24'(tx_udf), 24'd1);

    // R2: aligned pairs, distinct patterns.
    send_pair(12'h123, 12'h456, 1'b1, 1'b0, 1'b1);
    send_pair(12'h000, 12'hFFF, 1'b1, 1'b0, 1'b1);
    send_pair(12'hAAA, 12'h555, 1'b1, 1'b0, 1'b1);
    send_pair(12'hFFF, 12'h000, 1'b1, 1'b0, 1'b1);
    drain_rx("R2 R9");

    // R3: misframed words are skipped, pairing resumes.
    send_pair(12'h011, 12'h022, 1'b0, 1'b0, 1'b0);
    send_pair(12'h033, 12'h044, 1'b1, 1'b1, 1'b0);
    send_pair(12'h055, 12'h066, 1'b0, 1'b1, 1'b0);
    send_pair(12'h077, 12'h088, 1'b1, 1'b0, 1'b1);
    send_pair(12'h099, 12'h0AA, 1'b1, 1'b0, 1'b1);
    drain_rx("R3");

    // R7: no receive push while disabled.
    @(negedge clk); #0.5 en = 1'b0;
    send_pair(12'h321, 12'h654, 1'b1, 1'b0, 1'b0);
    send_pair(12'h987, 12'hCBA, 1'b1, 1'b0, 1'b0);
    drain_rx("R7");
    chk("R7 rx_empty", 24'(rx_empty), 24'd1);
    @(negedge clk); #0.5 en = 1'b1;

    // R4: overflow drops extra samples, keeps stored ones, flag sticks.
    chk("R4 no ovf yet", 24'(rx_ovf), 24'd0);
    for (int k = 0; k < RXD + 2; k++)
      send_pair(12'(12'h100 + k), 12'(12'h800 + k), 1'b1, 1'b0, 1'b1);
    @(posedge clk); #0.5;
    chk("R4 ovf set", 24'(rx_ovf), 24'd1);
    drain_rx("R4");
    chk("R4 ovf sticky", 24'(rx_ovf), 24'd1);

    // R8: ramp test mode from reset.
    do_reset();
    @(negedge clk); #0.5 en = 1'b1; ramp = 1'b1;
    repeat (5) @(posedge clk);
    #0.5 ramp = 1'b0;
    for (int k = 0; k < 5; k++) exp_rx.push_back({12'(k), 12'(k)});
    drain_rx("R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule